// File: doc/BRIEF.md
# Relative Call and Software Reset Sequencer

This block sits on the fetch side of a processor with 16-bit instruction words. It owns the program counter, a hardware return stack and the request for a full software reset. Each cycle it may be handed a fetched instruction word together with a valid strobe.

It acts on two encodings. The first is a PC-relative subroutine call. It stores the address of the next word on the return stack and jumps by a signed word offset. The call spends a second cycle as a bubble, and in that cycle the prefetched word is thrown away. The second encoding is a one-cycle software reset. It returns the program counter, the stack and the stack flags to their power-on state and raises a one-cycle pulse so that other register files can reset too. Every other valid word moves the program counter on by one word.

The program counter is a byte address, so it steps by 2 and its bit 0 is always 0. A simple pop port lets a return path remove the top stack entry. The external active-low reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `relcall_seq`

## Requirements
- R1: While the external reset is held, and after it is released, `pc`, `tos`, `stk_ovf`, `stk_unf`, `slot_kill` and `sw_rst_pulse` are all 0.
- R2: A valid word that is neither a call nor 0x00FF advances `pc` by 2 at the next edge. A cycle with `fetch_vld` low leaves `pc` unchanged.
- R3: A valid word whose bits [15:11] equal 5'b11011 is a call. Bits [10:0] form a two's complement word offset n in the range -1024 to +1023. At the next edge the value `pc`+2 is pushed, so `tos` shows it, and `pc` becomes `pc`+2+2n modulo 2^21.
- R4: After a call, `slot_kill` is 1 until the next valid fetch. That fetch is discarded: `pc` and the stack stay unchanged, even if the word is a call or 0x00FF. Cycles with `fetch_vld` low do not use up the bubble.
- R5: The valid word 16'h00FF sets `pc` to 0, empties the stack, clears both flags and drives `sw_rst_pulse` high for exactly the following cycle.
- R6: A call made while the stack already holds 31 entries still branches. Its push is dropped, `tos` is unchanged, and `stk_ovf` is set and stays set until a reset.
- R7: `pop_req` removes the top entry, and `tos` then shows the next entry, or 0 when the stack is empty. A pop on an empty stack sets `stk_unf`, which stays set until a reset.
- R8: A `pop_req` in the same cycle as an accepted call or software reset is ignored.
- R9: The external reset overrides any instruction in progress, including a pending bubble. After release, the block accepts a fetch from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| fetch_vld | input | 1 | `instr` holds a fetched word this cycle |
| instr | input | 16 | Fetched instruction word |
| pop_req | input | 1 | Remove the top return-stack entry |
| pc | output | 21 | Program counter, byte address |
| tos | output | 21 | Top of return stack, or 0 when empty |
| stk_ovf | output | 1 | Sticky: a push was dropped on a full stack |
| stk_unf | output | 1 | Sticky: a pop was made on an empty stack |
| slot_kill | output | 1 | The next valid fetch will be discarded |
| sw_rst_pulse | output | 1 | One-cycle request for a register-wide reset |

## Verification
The bench builds the block with its default parameters: a 21-bit program counter, a 16-bit word with an 11-bit offset field, and 31 stack entries. With these values the extreme offsets -1024 and +1023 carry the counter across both ends of its 2^21 range within a few vectors. Filling the stack and overflowing it needs only 32 back-to-back calls. A vector walk covers stepping, calls, bubble slots that hold a call or a reset word, and pops. Directed runs then cover overflow, underflow, and an external reset arriving during a bubble.

// File: rtl/relcall_pkg.sv
package relcall_pkg;
  typedef enum logic [1:0] {
    OP_STEP  = 2'd0,
    OP_CALL  = 2'd1,
    OP_SWRST = 2'd2
  } op_kind_e;

  localparam logic [4:0]  CALL_PREFIX = 5'b11011;
  localparam logic [15:0] SWRST_WORD  = 16'h00FF;
endpackage

// File: rtl/relcall_decode.sv
module relcall_decode
  import relcall_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OFF_W  = 11,
  parameter int PC_W   = 21
) (
  input  logic [WORD_W-1:0] word,
  output op_kind_e          kind,
  output logic [PC_W-1:0]   byte_disp
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  always_comb begin
    if (word[WORD_W-1 -: 5] == CALL_PREFIX) begin
      kind = OP_CALL;
    end else if (word == SWRST_WORD) begin
      kind = OP_SWRST;
    end else begin
      kind = OP_STEP;
    end
  end

  // word offset sign-extended and doubled into a byte displacement
  assign byte_disp = {{EXT_W{word[OFF_W-1]}}, word[OFF_W-1:0], 1'b0};
endmodule

// File: rtl/relcall_pcgen.sv
module relcall_pcgen
  import relcall_pkg::*;
#(
  parameter int PC_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld,
  input  op_kind_e        kind,
  input  logic [PC_W-1:0] byte_disp,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] ret_addr,
  output logic            kill_q,
  output logic            push_en,
  output logic            clr_en,
  output logic            swrst_q
);
  localparam logic [PC_W-1:0] WORD_STEP = PC_W'(2);

  logic            accept;
  logic [PC_W-1:0] pc_d;
  logic            kill_d;
  logic            pc_en;
  logic            kill_en;

  assign accept   = fetch_vld && !kill_q;
  assign ret_addr = pc_q + WORD_STEP;
  assign push_en  = accept && (kind == OP_CALL);
  assign clr_en   = accept && (kind == OP_SWRST);
  assign pc_en    = accept;
  assign kill_en  = fetch_vld;

  always_comb begin
    pc_d   = ret_addr;
    kill_d = 1'b0;
    case (kind)
      OP_CALL: begin
        pc_d   = ret_addr + byte_disp;
        kill_d = 1'b1;
      end
      OP_SWRST: pc_d = '0;
      default:  pc_d = ret_addr;
    endcase
    if (kill_q) begin
      kill_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      kill_q  <= 1'b0;
      swrst_q <= 1'b0;
    end else begin
      if (pc_en) begin
        pc_q <= pc_d;
      end
      if (kill_en) begin
        kill_q <= kill_d;
      end
      swrst_q <= clr_en;
    end
  end

  a_r1_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);
  a_r2_step_adds_two: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == OP_STEP) |=> (pc_q == $past(pc_q) + WORD_STEP));
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld |=> $stable(pc_q));
  a_r3_call_arms_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == OP_CALL) |=> kill_q);
  a_r4_killed_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && fetch_vld) |=> ($stable(pc_q) && !kill_q && !swrst_q));
  a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> !swrst_q);
endmodule

// File: rtl/relcall_rstack.sv
module relcall_rstack #(
  parameter int DEPTH = 31,
  parameter int DW    = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  input  logic          clr_en,
  output logic [DW-1:0] tos,
  output logic          ovf_q,
  output logic          unf_q
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_d, unf_d;
  logic             pop_en, full, empty, wr_en;
  logic [IDX_W-1:0] wr_idx, top_idx;

  assign full    = (cnt_q == FULL);
  assign empty   = (cnt_q == '0);
  assign pop_en  = pop_req && !push_en && !clr_en;
  assign wr_en   = push_en && !full;
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign tos     = empty ? '0 : mem[top_idx];

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (clr_en) begin
      cnt_d = '0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else if (push_en) begin
      if (full) ovf_d = 1'b1;
      else      cnt_d = cnt_q + CNT_W'(1);
    end else if (pop_en) begin
      if (empty) unf_d = 1'b1;
      else       cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // storage entries carry no reset; occupancy alone defines validity
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem[g] <= push_data;
      end
    end
  end

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_en) |=> ovf_q);
  a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && full) |=> (ovf_q && $stable(tos)));
  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !clr_en) |=> unf_q);
  a_r3_push_shows_tos: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !full) |=> (tos == $past(push_data)));
  a_r8_pop_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && push_en && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/relcall_seq.sv
module relcall_seq
  import relcall_pkg::*;
#(
  parameter int PC_W      = 21,
  parameter int WORD_W    = 16,
  parameter int OFF_W     = 11,
  parameter int STK_DEPTH = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_vld,
  input  logic [WORD_W-1:0] instr,
  input  logic              pop_req,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   tos,
  output logic              stk_ovf,
  output logic              stk_unf,
  output logic              slot_kill,
  output logic              sw_rst_pulse
);
  logic            rst_meta_q, rst_sync_n;
  op_kind_e        kind;
  logic [PC_W-1:0] byte_disp, ret_addr;
  logic            push_en, clr_en;

  // asynchronous assertion, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  relcall_decode #(.WORD_W(WORD_W), .OFF_W(OFF_W), .PC_W(PC_W)) u_dec (
    .word      (instr),
    .kind      (kind),
    .byte_disp (byte_disp)
  );

  relcall_pcgen #(.PC_W(PC_W)) u_pcgen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fetch_vld (fetch_vld),
    .kind      (kind),
    .byte_disp (byte_disp),
    .pc_q      (pc),
    .ret_addr  (ret_addr),
    .kill_q    (slot_kill),
    .push_en   (push_en),
    .clr_en    (clr_en),
    .swrst_q   (sw_rst_pulse)
  );

  relcall_rstack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_en   (push_en),
    .push_data (ret_addr),
    .pop_req   (pop_req),
    .clr_en    (clr_en),
    .tos       (tos),
    .ovf_q     (stk_ovf),
    .unf_q     (stk_unf)
  );

  a_r5_pulse_after_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sw_rst_pulse |-> (pc == '0 && tos == '0 && !stk_ovf && !stk_unf));
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (pc == '0 && !slot_kill && !sw_rst_pulse));
endmodule

// File: tb/relcall_seq_bench.sv
`timescale 1ns/1ps
module relcall_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        pop_req = 1'b0;
  logic [20:0] pc, tos;
  logic        stk_ovf, stk_unf, slot_kill, sw_rst_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  relcall_seq u_relcall_seq (
    .clk, .rst_n, .fetch_vld, .instr, .pop_req,
    .pc, .tos, .stk_ovf, .stk_unf, .slot_kill, .sw_rst_pulse
  );

  // {vld, pop, instr, exp_pc, exp_tos, exp_kill, exp_pulse}
  localparam int NV = 18;
  localparam logic [61:0] VEC [NV] = '{
    {1'b1,1'b0,16'h0000,21'h000002,21'h000000,1'b0,1'b0}, // R2 step
    {1'b1,1'b0,16'hD805,21'h00000E,21'h000004,1'b1,1'b0}, // R3 n=+5
    {1'b1,1'b0,16'h1234,21'h00000E,21'h000004,1'b0,1'b0}, // R4 discard
    {1'b1,1'b0,16'h0000,21'h000010,21'h000004,1'b0,1'b0}, // R2
    {1'b0,1'b0,16'hD805,21'h000010,21'h000004,1'b0,1'b0}, // R2 idle
    {1'b1,1'b0,16'hDFFF,21'h000010,21'h000012,1'b1,1'b0}, // R3 n=-1
    {1'b1,1'b0,16'hD805,21'h000010,21'h000012,1'b0,1'b0}, // R4 call in slot
    {1'b1,1'b0,16'hDC00,21'h1FF812,21'h000012,1'b1,1'b0}, // R3 n=-1024 wrap
    {1'b1,1'b0,16'h0000,21'h1FF812,21'h000012,1'b0,1'b0}, // R4
    {1'b1,1'b0,16'hDBFF,21'h000012,21'h1FF814,1'b1,1'b0}, // R3 n=+1023 wrap
    {1'b0,1'b0,16'h0000,21'h000012,21'h1FF814,1'b1,1'b0}, // R4 idle keeps bubble
    {1'b1,1'b0,16'h0000,21'h000012,21'h1FF814,1'b0,1'b0}, // R4
    {1'b0,1'b1,16'h0000,21'h000012,21'h000012,1'b0,1'b0}, // R7 pop
    {1'b1,1'b1,16'h0000,21'h000014,21'h000012,1'b0,1'b0}, // R7 pop with step
    {1'b1,1'b1,16'hD800,21'h000016,21'h000016,1'b1,1'b0}, // R8 pop ignored
    {1'b1,1'b0,16'h00FF,21'h000016,21'h000016,1'b0,1'b0}, // R4 reset word in slot
    {1'b1,1'b0,16'h00FF,21'h000000,21'h000000,1'b0,1'b1}, // R5
    {1'b1,1'b0,16'h0000,21'h000002,21'h000000,1'b0,1'b0}  // R5 pulse drops
  };

  task automatic chk(input string req, input string what, input logic [20:0] act,
                     input logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic p, input logic [15:0] w);
    @(negedge clk);
    fetch_vld = v;
    pop_req   = p;
    instr     = w;
    @(posedge clk);
    #1;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [20:0] base;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc in reset", pc, 21'h0);
    chk("R1", "slot_kill in reset", {20'h0, slot_kill}, 21'h0);
    release_reset();
    chk("R1", "pc after release", pc, 21'h0);
    chk("R1", "tos after release", tos, 21'h0);
    chk("R1", "flags after release", {19'h0, stk_ovf, stk_unf}, 21'h0);
    chk("R1", "pulse after release", {20'h0, sw_rst_pulse}, 21'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][61], VEC[i][60], VEC[i][59:44]);
      // rows exercise R2 R3 R4 R5 R7 R8
      chk("R2/R3/R4/R5/R7/R8 vector", "pc", pc, VEC[i][43:23]);
      chk("R3/R7 vector", "tos", tos, VEC[i][22:2]);
      chk("R4 vector", "slot_kill", {20'h0, slot_kill}, {20'h0, VEC[i][1]});
      chk("R5 vector", "sw_rst_pulse", {20'h0, sw_rst_pulse}, {20'h0, VEC[i][0]});
      chk("R6/R7 vector", "flags", {19'h0, stk_ovf, stk_unf}, 21'h0);
    end

    // R6: fill 31 entries, then one more call
    base = pc;
    for (int k = 1; k <= 32; k++) begin
      step(1'b1, 1'b0, 16'hD800);
      step(1'b1, 1'b0, 16'h0000);
    end
    chk("R6", "pc after 32 calls", pc, base + 21'd64);
    chk("R6", "tos keeps 31st push", tos, base + 21'd62);
    chk("R6", "stk_ovf set", {20'h0, stk_ovf}, 21'h1);
    step(1'b0, 1'b1, 16'h0000);
    chk("R6", "pop after overflow", tos, base + 21'd60);
    chk("R6", "stk_ovf sticky", {20'h0, stk_ovf}, 21'h1);

    // R9: external reset during a pending bubble
    step(1'b1, 1'b0, 16'hD805);
    chk("R9", "bubble armed", {20'h0, slot_kill}, 21'h1);
    @(negedge clk);
    fetch_vld = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "async pc", pc, 21'h0);
    chk("R9", "async kill", {20'h0, slot_kill}, 21'h0);
    chk("R9", "async ovf", {20'h0, stk_ovf}, 21'h0);
    release_reset();
    step(1'b1, 1'b0, 16'h0000);
    chk("R9", "first fetch accepted", pc, 21'h2);

    // R7: underflow, sticky, cleared by software reset (R5)
    step(1'b0, 1'b1, 16'h0000);
    chk("R7", "stk_unf set", {20'h0, stk_unf}, 21'h1);
    chk("R7", "tos empty", tos, 21'h0);
    step(1'b1, 1'b0, 16'h0000);
    chk("R7", "stk_unf sticky", {20'h0, stk_unf}, 21'h1);
    step(1'b1, 1'b0, 16'h00FF);
    chk("R5", "unf cleared", {20'h0, stk_unf}, 21'h0);
    chk("R5", "pulse", {20'h0, sw_rst_pulse}, 21'h1);
    chk("R5", "pc cleared", pc, 21'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule